// File: doc/BRIEF.md
# Multi-Cycle Floating-Point Issue Interlock

This block sits at the issue point of an in-order pipeline. Integer operations finish execute in one cycle. Floating-point add/subtract and divide operations stay in their execute units for several cycles. Because these latencies differ, results can complete out of program order, and two instructions can reach the single write-back port in the same cycle. Each cycle the block looks at the decoded instruction: its destination, its two optional sources and its unit class. It asserts `stall` when issuing that instruction now would break program semantics or the one-write-per-cycle rule.

The block keeps two pieces of state. The first is a pending bit for each register, set when a floating-point result is issued and cleared when that result is written back. The second is a reservation line with one slot for each future cycle; every slot records which register is written back in that cycle. When `stall` is high, fetch and decode hold their contents and the execute stage takes a bubble. The block works out write-back times from its own reservation line, so it needs no completion input.

Top module: `fp_issue_interlock`

## Requirements
- R1: `stall` is low whenever `idValid` is low. `issue` equals `idValid` and not `stall`.
- R2: Unit codes on `idUnit` are 0 for integer (latency INT_LAT, default 1), 1 for FP add/subtract (ADD_LAT, default 4) and 2 for divide (DIV_LAT, default 8). Code 3 is handled as a divide.
- R3: An instruction that reads an enabled source whose value is still owed by an in-flight FP operation stalls. If it directly follows a producer of latency L, it stalls for exactly L cycles.
- R4: Reading the result of an integer operation never stalls, because that value is assumed to be forwarded.
- R5: A writing instruction whose destination has an FP result still in flight stalls until that older result has been written back. Directly after a producer of latency L, this lasts exactly L cycles.
- R6: A writing instruction stalls if its write-back cycle is already reserved. Example: a divide followed by three integer operations, then an FP add, stalls the add for one cycle. An FP add followed by three integer operations stalls the third integer operation for one cycle.
- R7: A source with its use flag low, and the destination of an instruction whose write flag is low, take no part in the checks and do not cause a stall.
- R8: Writing a register that an older, still-executing instruction reads (WAR) causes no stall.
- R9: Reset clears every pending bit and every write-back reservation, so a register in flight before reset causes no stall after it.
- R10: Independent integer operations with distinct registers issue on consecutive cycles without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idValid | input | 1 | Decode holds a valid instruction |
| idUnit | input | 2 | Unit class: 0 integer, 1 FP add/sub, 2 divide, 3 divide |
| idWrites | input | 1 | Instruction writes a destination register |
| idDest | input | $clog2(NUM_REGS) | Destination register |
| idUseA | input | 1 | Source A is read |
| idSrcA | input | $clog2(NUM_REGS) | Source A register |
| idUseB | input | 1 | Source B is read |
| idSrcB | input | $clog2(NUM_REGS) | Source B register |
| stall | output | 1 | Hold fetch/decode and insert a bubble |
| issue | output | 1 | Instruction leaves decode this cycle |

## Verification
The bench builds the block with its default parameters: 32 registers and latencies of 1, 4 and 8. With these values the whole reservation line is eight slots long. A single divide therefore covers every slot position, and the stall length for each unit can be counted and compared with its latency. The spacing of 1 against 4 against 8 allows short integer sequences that land exactly on a reserved write-back slot from either side.

// File: rtl/fp_issue_pkg.sv
package fp_issue_pkg;

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_DIV = 2'd2,
    UNIT_RSV = 2'd3
  } unit_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic  issue;     // instruction leaves decode at this edge
    logic  book;      // claim a write-back slot
    logic  markPend;  // result is long-latency: set pending bit
    unit_e unit;      // selects latency
  } strobe_t;

  function automatic int latOf(unit_e u, int intL, int addL, int divL);
    case (u)
      UNIT_INT: return intL;
      UNIT_ADD: return addL;
      default:  return divL;
    endcase
  endfunction

endpackage

// File: rtl/fp_issue_ctrl.sv
module fp_issue_ctrl
  import fp_issue_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int INT_LAT  = 1,
  parameter int ADD_LAT  = 4,
  parameter int DIV_LAT  = 8,
  parameter int DEPTH    = 8,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int IDX_W   = $clog2(DEPTH + 1)
) (
  input  logic                idValid,
  input  unit_e               idUnit,
  input  logic                idWrites,
  input  logic [REG_W-1:0]    idDest,
  input  logic                idUseA,
  input  logic [REG_W-1:0]    idSrcA,
  input  logic                idUseB,
  input  logic [REG_W-1:0]    idSrcB,
  input  logic [NUM_REGS-1:0] pendVec,
  input  logic [DEPTH:0]      busyNext,
  output logic                stall,
  output strobe_t             strb
);

  logic [IDX_W-1:0] latIdx;
  logic rawHaz, wawHaz, portHaz, anyHaz;

  always_comb begin
    latIdx  = IDX_W'(latOf(idUnit, INT_LAT, ADD_LAT, DIV_LAT));
    rawHaz  = (idUseA && pendVec[idSrcA]) || (idUseB && pendVec[idSrcB]);
    wawHaz  = idWrites && pendVec[idDest];
    portHaz = idWrites && busyNext[latIdx];
    anyHaz  = rawHaz || wawHaz || portHaz;
    stall   = idValid && anyHaz;

    strb.issue    = idValid && !anyHaz;
    strb.book     = idValid && !anyHaz && idWrites;
    strb.markPend = idValid && !anyHaz && idWrites && (idUnit != UNIT_INT);
    strb.unit     = idUnit;
  end

endmodule

// File: rtl/fp_issue_track.sv
module fp_issue_track
  import fp_issue_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int INT_LAT  = 1,
  parameter int ADD_LAT  = 4,
  parameter int DIV_LAT  = 8,
  parameter int DEPTH    = 8,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int IDX_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [REG_W-1:0]    idDest,
  output logic [NUM_REGS-1:0] pendVec,
  output logic [DEPTH:0]      busyNext
);

  typedef struct packed {
    logic             vld;
    logic             pend;
    logic [REG_W-1:0] dst;
  } slot_t;

  // slotQ[k]: result written back k cycles from now
  slot_t slotQ [1:DEPTH];
  logic [NUM_REGS-1:0] pendQ, setMask, clrMask;
  logic [IDX_W-1:0] latIdx;

  assign latIdx = IDX_W'(latOf(strb.unit, INT_LAT, ADD_LAT, DIV_LAT));

  // occupancy each slot will have after the next shift
  assign busyNext[0] = 1'b0;
  generate
    for (genvar k = 1; k <= DEPTH; k++) begin : g_busy
      if (k < DEPTH) begin : g_mid
        assign busyNext[k] = slotQ[k+1].vld;
      end else begin : g_top
        assign busyNext[k] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 1; k <= DEPTH; k++) slotQ[k] <= '0;
    end else begin
      for (int k = 1; k <= DEPTH; k++) begin
        if (strb.book && latIdx == IDX_W'(k)) begin
          slotQ[k] <= '{vld: 1'b1, pend: strb.markPend, dst: idDest};
        end else if (k < DEPTH) begin
          slotQ[k] <= slotQ[k+1];
        end else begin
          slotQ[k] <= '0;
        end
      end
    end
  end

  always_comb begin
    setMask = '0;
    clrMask = '0;
    if (strb.markPend) setMask[idDest] = 1'b1;
    if (slotQ[1].vld && slotQ[1].pend) clrMask[slotQ[1].dst] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrMask) | setMask;
  end

  assign pendVec = pendQ;

  int pendSlots;
  always_comb begin
    pendSlots = 0;
    for (int k = 1; k <= DEPTH; k++)
      if (slotQ[k].vld && slotQ[k].pend) pendSlots++;
  end

  // R6: a claimed write-back slot must be free
  p_slot_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.book |-> !busyNext[latIdx]);

  // R5: no second in-flight writer of a pending register
  p_no_waw_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.book |-> !pendQ[idDest]);

  // R3: every pending bit is backed by an in-flight reservation
  p_pend_backed_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pendQ) <= pendSlots);

  // R9: state is empty when reset releases
  p_reset_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pendQ == '0 && busyNext == '0));

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import fp_issue_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int INT_LAT  = 1,
  parameter int ADD_LAT  = 4,
  parameter int DIV_LAT  = 8,
  localparam int MAX_AI  = (ADD_LAT > INT_LAT) ? ADD_LAT : INT_LAT,
  localparam int DEPTH   = (DIV_LAT > MAX_AI) ? DIV_LAT : MAX_AI,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idValid,
  input  logic [1:0]       idUnit,
  input  logic             idWrites,
  input  logic [REG_W-1:0] idDest,
  input  logic             idUseA,
  input  logic [REG_W-1:0] idSrcA,
  input  logic             idUseB,
  input  logic [REG_W-1:0] idSrcB,
  output logic             stall,
  output logic             issue
);

  strobe_t             strb;
  logic [NUM_REGS-1:0] pendVec;
  logic [DEPTH:0]      busyNext;

  fp_issue_ctrl #(
    .NUM_REGS(NUM_REGS), .INT_LAT(INT_LAT), .ADD_LAT(ADD_LAT),
    .DIV_LAT(DIV_LAT), .DEPTH(DEPTH)
  ) u_ctrl (
    .idValid (idValid),
    .idUnit  (unit_e'(idUnit)),
    .idWrites(idWrites),
    .idDest  (idDest),
    .idUseA  (idUseA),
    .idSrcA  (idSrcA),
    .idUseB  (idUseB),
    .idSrcB  (idSrcB),
    .pendVec (pendVec),
    .busyNext(busyNext),
    .stall   (stall),
    .strb    (strb)
  );

  fp_issue_track #(
    .NUM_REGS(NUM_REGS), .INT_LAT(INT_LAT), .ADD_LAT(ADD_LAT),
    .DIV_LAT(DIV_LAT), .DEPTH(DEPTH)
  ) u_track (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .idDest  (idDest),
    .pendVec (pendVec),
    .busyNext(busyNext)
  );

  assign issue = strb.issue;

  // R1: no stall without a valid instruction
  p_idle_no_stall_r1: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |-> !stall);

  // R3: an issued reader never sees a pending source
  p_raw_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (issue && idUseA) |-> !pendVec[idSrcA]);

endmodule

// File: tb/sim_fp_issue_interlock.sv
module sim_fp_issue_interlock;

  localparam int NREG = 32;
  localparam int RW   = $clog2(NREG);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idValid = 1'b0;
  logic [1:0] idUnit = 2'd0;
  logic idWrites = 1'b0;
  logic [RW-1:0] idDest = '0;
  logic idUseA = 1'b0;
  logic [RW-1:0] idSrcA = '0;
  logic idUseB = 1'b0;
  logic [RW-1:0] idSrcB = '0;
  logic stall, issue;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  fp_issue_interlock #(.NUM_REGS(NREG)) u0 (
    .clk(clk), .rstN(rstN), .idValid(idValid), .idUnit(idUnit),
    .idWrites(idWrites), .idDest(idDest), .idUseA(idUseA), .idSrcA(idSrcA),
    .idUseB(idUseB), .idSrcB(idSrcB), .stall(stall), .issue(issue)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    idValid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  // present one instruction, count stalled cycles, let it issue
  task automatic present(input logic [1:0] u, input logic wr, input int d,
                         input logic ua, input int sa, input logic ub,
                         input int sb, output int stalls);
    @(negedge clk);
    idValid = 1'b1; idUnit = u; idWrites = wr; idDest = RW'(d);
    idUseA = ua; idSrcA = RW'(sa); idUseB = ub; idSrcB = RW'(sb);
    stalls = 0;
    #1;
    while (stall && stalls < 100) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    check("R1 issue when not stalled", int'(issue), 1);
    @(posedge clk);
  endtask

  task automatic t_reset;
    int s;
    rstN = 1'b0;
    @(negedge clk);
    idValid = 1'b1; idUnit = 2'd2; idWrites = 1'b1; idDest = 5'd1;
    idUseA = 1'b1; idSrcA = 5'd1;
    #1;
    check("R9 stall in reset", int'(stall), 0);
    @(negedge clk);
    rstN = 1'b1;
    idValid = 1'b0;
    #1;
    check("R1 idle stall", int'(stall), 0);
    check("R1 idle issue", int'(issue), 0);
    present(2'd1, 1'b1, 30, 1'b0, 0, 1'b0, 0, s);
    check("R9 first issue clean", s, 0);
    idle(10);
  endtask

  task automatic t_raw;
    int s;
    present(2'd2, 1'b1, 1, 1'b0, 0, 1'b0, 0, s);
    present(2'd1, 1'b1, 2, 1'b1, 1, 1'b0, 0, s);
    check("R3 R2 divide RAW length", s, 8);
    idle(12);
    present(2'd1, 1'b1, 3, 1'b0, 0, 1'b0, 0, s);
    present(2'd0, 1'b1, 4, 1'b0, 0, 1'b1, 3, s);
    check("R3 R2 add RAW on srcB length", s, 4);
    idle(12);
  endtask

  task automatic t_int_fwd;
    int s;
    present(2'd0, 1'b1, 5, 1'b0, 0, 1'b0, 0, s);
    present(2'd0, 1'b1, 6, 1'b1, 5, 1'b0, 0, s);
    check("R4 integer result no stall", s, 0);
    idle(4);
  endtask

  task automatic t_waw;
    int s;
    present(2'd2, 1'b1, 7, 1'b0, 0, 1'b0, 0, s);
    present(2'd0, 1'b1, 7, 1'b0, 0, 1'b0, 0, s);
    check("R5 WAW behind divide", s, 8);
    idle(12);
    present(2'd3, 1'b1, 8, 1'b0, 0, 1'b0, 0, s);
    present(2'd0, 1'b1, 8, 1'b0, 0, 1'b0, 0, s);
    check("R5 R2 code 3 as divide", s, 8);
    idle(12);
  endtask

  task automatic t_port;
    int s;
    present(2'd2, 1'b1, 9, 1'b0, 0, 1'b0, 0, s);
    present(2'd0, 1'b1, 10, 1'b0, 0, 1'b0, 0, s);
    present(2'd0, 1'b1, 11, 1'b0, 0, 1'b0, 0, s);
    present(2'd0, 1'b1, 12, 1'b0, 0, 1'b0, 0, s);
    check("R6 ints beside divide", s, 0);
    present(2'd1, 1'b1, 13, 1'b0, 0, 1'b0, 0, s);
    check("R6 add collides with divide", s, 1);
    idle(12);
    present(2'd1, 1'b1, 14, 1'b0, 0, 1'b0, 0, s);
    present(2'd0, 1'b1, 15, 1'b0, 0, 1'b0, 0, s);
    present(2'd0, 1'b1, 16, 1'b0, 0, 1'b0, 0, s);
    check("R6 second int free", s, 0);
    present(2'd0, 1'b1, 17, 1'b0, 0, 1'b0, 0, s);
    check("R6 third int collides with add", s, 1);
    idle(12);
  endtask

  task automatic t_ignore;
    int s;
    present(2'd2, 1'b1, 18, 1'b0, 0, 1'b0, 0, s);
    @(negedge clk);
    idValid = 1'b0; idUseA = 1'b1; idSrcA = 5'd18; idWrites = 1'b1;
    idDest = 5'd18;
    #1;
    check("R1 invalid hazard no stall", int'(stall), 0);
    present(2'd0, 1'b0, 18, 1'b0, 18, 1'b0, 18, s);
    check("R7 unused fields ignored", s, 0);
    idle(12);
  endtask

  task automatic t_war;
    int s;
    present(2'd1, 1'b1, 21, 1'b1, 20, 1'b0, 0, s);
    present(2'd2, 1'b1, 20, 1'b0, 0, 1'b0, 0, s);
    check("R8 WAR no stall", s, 0);
    idle(12);
  endtask

  task automatic t_reset_mid;
    int s;
    present(2'd2, 1'b1, 22, 1'b0, 0, 1'b0, 0, s);
    idle(2);
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    present(2'd0, 1'b1, 23, 1'b1, 22, 1'b0, 0, s);
    check("R9 pending cleared RAW", s, 0);
    present(2'd1, 1'b1, 22, 1'b0, 0, 1'b0, 0, s);
    check("R9 pending cleared WAW", s, 0);
    idle(12);
  endtask

  task automatic t_stream;
    int s;
    int tot = 0;
    for (int i = 0; i < 6; i++) begin
      present(2'd0, 1'b1, 24 + i, 1'b1, 2 + i, 1'b0, 0, s);
      tot += s;
    end
    check("R10 back-to-back ints", tot, 0);
    idle(4);
  endtask

  initial begin
    t_reset();
    t_raw();
    t_int_fwd();
    t_waw();
    t_port();
    t_ignore();
    t_war();
    t_reset_mid();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule